// File: doc/BRIEF.md
# Sequential Integer Divider with Overflow Flags

This block divides a dividend by a divisor one quotient bit per clock cycle, in signed or unsigned arithmetic, and in three forms. The half form divides a full register by the low half of the divisor and packs remainder and quotient into one register. The single form divides one register by a full-width divisor. The double form divides a two-register dividend by a full-width divisor.

The surrounding pipeline reads the operand registers, pulses `start_i` with the form, the signedness and the two destination indices, and waits for `done_o`. On completion the block raises write strobes for the register file and updates the N, Z, V and C condition flags. A zero divisor raises a trap instead of running. When the quotient cannot be represented, the block reports overflow in V and writes nothing back.

Top module: `div_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `trap_o`, both write strobes and all four flags are low. A start is accepted on a clock edge where `busy_o` is low. For a non-zero divisor, `busy_o` is high from the next cycle until `done_o`. `done_o` is a one-cycle pulse that appears S+1 cycles after the accepting edge, where S = W for the half and single forms and S = 2W for the double form. In that cycle `busy_o` is already low.
- R2: A `start_i` that arrives while `busy_o` is high is ignored. It does not change the running result and does not cause a later `done_o`.
- R3: A divisor equal to zero, taken in the width of the selected form, gives `trap_o` and `done_o` in the cycle right after the accepting edge. No write strobe is raised and all flags keep their values.
- R4: Every division that is not trapped leaves C cleared, including divisions that overflow.
- R5: Half form (`mode_i` = 2'b00): the dividend is `quo_val_i` and the divisor is `divisor_i[W/2-1:0]`. The block writes only the register at `quo_idx_i`, with the remainder in bits W-1:W/2 and the quotient in bits W/2-1:0. N is bit W/2-1 of the quotient and Z reports whether the low W/2 quotient bits are zero.
- R6: Half form overflow occurs when an unsigned quotient exceeds 2^(W/2)-1, or when a signed quotient lies outside -2^(W/2-1) .. 2^(W/2-1)-1.
- R7: On overflow, V is set, Z is cleared, N keeps its previous value and no write strobe is raised.
- R8: Double form (`mode_i` = 2'b10): the dividend is {`rem_val_i`, `quo_val_i`}, with `rem_val_i` as the upper half. Overflow occurs when the quotient does not fit in W bits, under the selected signedness.
- R9: Single and double forms write the remainder to `rem_idx_i` and the quotient to `quo_idx_i`. When the two indices are equal, only the quotient write is raised.
- R10: Single form (`mode_i` = 2'b01, and likewise 2'b11): the dividend is `quo_val_i`. This form never overflows, V is cleared, the quotient is truncated to W bits, and N and Z come from that W-bit quotient.
- R11: With `signed_i` high the operands are two's complement, the quotient rounds toward zero and a non-zero remainder takes the sign of the dividend. With `signed_i` low both operands are unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| mode_i | input | 2 | Form: 00 half, 01 single, 10 double |
| signed_i | input | 1 | Signed arithmetic when high |
| quo_val_i | input | W | Value of the quotient register (dividend, or low dividend half) |
| rem_val_i | input | W | Value of the remainder register (high dividend half in double form) |
| divisor_i | input | W | Divisor |
| quo_idx_i | input | IW | Index of the quotient register |
| rem_idx_i | input | IW | Index of the remainder register |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Completion pulse |
| trap_o | output | 1 | Divide-by-zero trap, with done_o |
| quo_we_o | output | 1 | Quotient write strobe |
| quo_waddr_o | output | IW | Quotient write index |
| quo_wdata_o | output | W | Quotient write data |
| rem_we_o | output | 1 | Remainder write strobe |
| rem_waddr_o | output | IW | Remainder write index |
| rem_wdata_o | output | W | Remainder write data |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The assertions run on every cycle. They check that a trap never comes with a write strobe and never changes a flag, that an overflowing completion writes nothing, clears Z and holds N, and that a remainder write never shares its index with the quotient write or occurs in half form. They also check that the engine is loaded only when idle and that busy and done never overlap. The arithmetic itself can only be shown by the bench's scenarios: quotient and remainder values, the overflow limits of each form and signedness, and the exact completion latency. The same holds for a start pulse issued mid-division being dropped. The bench sweeps every half-form operand pair at W = 8 and samples the other two forms widely around their boundaries.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
  typedef enum logic [1:0] {
    FORM_HALF   = 2'd0,
    FORM_SINGLE = 2'd1,
    FORM_DOUBLE = 2'd2
  } div_form_e;
endpackage

// File: rtl/div_prep.sv
`timescale 1ns/1ps
// Operand conditioning: sign handling, magnitudes, alignment, step count.
module div_prep import div_pkg::*; #(
  parameter int W = 32
) (
  input  logic [1:0]              mode_i,
  input  logic                    sgn_i,
  input  logic [W-1:0]            lo_i,
  input  logic [W-1:0]            hi_i,
  input  logic [W-1:0]            dvs_i,
  output logic [2*W-1:0]          dvd_o,
  output logic [W-1:0]            dvs_mag_o,
  output logic [$clog2(2*W+1)-1:0] steps_o,
  output logic                    dvd_neg_o,
  output logic                    dvs_neg_o,
  output logic                    dvs_zero_o
);
  localparam int HW = W / 2;
  localparam int CW = $clog2(2*W+1);

  logic           is_half, is_double;
  logic [W-1:0]   dvs_ext;
  logic [2*W-1:0] dvd_ext, dvd_mag;

  always_comb begin
    is_half   = (mode_i == FORM_HALF);
    is_double = (mode_i == FORM_DOUBLE);

    if (is_half)
      dvs_ext = sgn_i ? {{HW{dvs_i[HW-1]}}, dvs_i[HW-1:0]} : {{HW{1'b0}}, dvs_i[HW-1:0]};
    else
      dvs_ext = dvs_i;
    dvs_neg_o  = sgn_i & dvs_ext[W-1];
    dvs_mag_o  = dvs_neg_o ? -dvs_ext : dvs_ext;
    dvs_zero_o = (dvs_ext == '0);

    dvd_ext   = is_double ? {hi_i, lo_i} : {{W{sgn_i & lo_i[W-1]}}, lo_i};
    dvd_neg_o = sgn_i & dvd_ext[2*W-1];
    dvd_mag   = dvd_neg_o ? -dvd_ext : dvd_ext;
    // single-register dividends start at the top so W steps suffice
    dvd_o     = is_double ? dvd_mag : {dvd_mag[W-1:0], {W{1'b0}}};
    steps_o   = is_double ? CW'(2*W) : CW'(W);
  end
endmodule

// File: rtl/div_core.sv
`timescale 1ns/1ps
// Non-restoring magnitude divider, one quotient bit per cycle.
module div_core #(
  parameter int W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [2*W-1:0]           dvd_i,
  input  logic [W-1:0]             dvs_i,
  input  logic [$clog2(2*W+1)-1:0] steps_i,
  output logic                     busy_o,
  output logic                     fin_o,
  output logic [2*W-1:0]           quo_o,
  output logic [W-1:0]             rem_o
);
  localparam int CW = $clog2(2*W+1);

  logic [W+1:0]   r_q, r_nx, r_sh, d_ext;
  logic [2*W-1:0] q_q, q_nx;
  logic [W-1:0]   d_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, fin_q;

  always_comb begin
    d_ext = {2'b00, d_q};
    r_sh  = {r_q[W:0], q_q[2*W-1]};
    r_nx  = r_q[W+1] ? (r_sh + d_ext) : (r_sh - d_ext);
    q_nx  = {q_q[2*W-2:0], ~r_nx[W+1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q    <= '0;
      q_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (load_i) begin
      r_q    <= '0;
      q_q    <= dvd_i;
      d_q    <= dvs_i;
      cnt_q  <= steps_i;
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (busy_q) begin
        r_q   <= r_nx;
        q_q   <= q_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = fin_q;
  assign quo_o  = q_q;
  // final correction of a negative partial remainder
  assign rem_o  = r_q[W+1] ? (r_q[W-1:0] + d_q) : r_q[W-1:0];

  a_r2_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
  a_r1_fin_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> $past(busy_q));
endmodule

// File: rtl/div_post.sv
`timescale 1ns/1ps
// Result sign fix-up, overflow detection and N/Z derivation.
module div_post import div_pkg::*; #(
  parameter int W = 32
) (
  input  logic [1:0]     mode_i,
  input  logic           sgn_i,
  input  logic           qneg_i,
  input  logic           rneg_i,
  input  logic [2*W-1:0] qmag_i,
  input  logic [W-1:0]   rmag_i,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o,
  output logic           ovf_o,
  output logic           neg_o,
  output logic           zero_o
);
  localparam int HW = W / 2;
  localparam logic [2*W-1:0] H_UMAX = {{(2*W-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [2*W-1:0] H_SMAX = {{(2*W-HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [2*W-1:0] F_UMAX = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [2*W-1:0] F_SMAX = {{(W+1){1'b0}}, {(W-1){1'b1}}};

  logic           is_half, is_double;
  logic [2*W-1:0] lim;

  always_comb begin
    is_half   = (mode_i == FORM_HALF);
    is_double = (mode_i == FORM_DOUBLE);

    quot_o = qneg_i ? -qmag_i[W-1:0] : qmag_i[W-1:0];
    rem_o  = rneg_i ? -rmag_i : rmag_i;

    if (is_half)
      lim = sgn_i ? (qneg_i ? H_SMAX + 1'b1 : H_SMAX) : H_UMAX;
    else
      lim = sgn_i ? (qneg_i ? F_SMAX + 1'b1 : F_SMAX) : F_UMAX;
    ovf_o = (is_half || is_double) && (qmag_i > lim);

    if (is_half) begin
      neg_o  = quot_o[HW-1];
      zero_o = (quot_o[HW-1:0] == '0);
    end else begin
      neg_o  = quot_o[W-1];
      zero_o = (quot_o == '0);
    end
  end
endmodule

// File: rtl/div_unit.sv
`timescale 1ns/1ps
module div_unit import div_pkg::*; #(
  parameter int W  = 32,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          signed_i,
  input  logic [W-1:0]  quo_val_i,
  input  logic [W-1:0]  rem_val_i,
  input  logic [W-1:0]  divisor_i,
  input  logic [IW-1:0] quo_idx_i,
  input  logic [IW-1:0] rem_idx_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          trap_o,
  output logic          quo_we_o,
  output logic [IW-1:0] quo_waddr_o,
  output logic [W-1:0]  quo_wdata_o,
  output logic          rem_we_o,
  output logic [IW-1:0] rem_waddr_o,
  output logic [W-1:0]  rem_wdata_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_v_o,
  output logic          flag_c_o
);
  localparam int HW = W / 2;
  localparam int CW = $clog2(2*W+1);

  logic [2*W-1:0] p_dvd;
  logic [W-1:0]   p_dvs;
  logic [CW-1:0]  p_steps;
  logic           p_dvd_neg, p_dvs_neg, p_zero;

  logic           c_busy, c_fin;
  logic [2*W-1:0] c_quo;
  logic [W-1:0]   c_rem;

  logic [W-1:0]   r_quot, r_rem;
  logic           r_ovf, r_neg, r_zero;

  logic [1:0]     mode_q;
  logic           sgn_q, qneg_q, rneg_q, busy_q, done_q, trap_q;
  logic [IW-1:0]  qidx_q, ridx_q;
  logic           qwe_q, rwe_q;
  logic [IW-1:0]  qaddr_q, raddr_q;
  logic [W-1:0]   qdata_q, rdata_q;
  logic           n_q, z_q, v_q, c_q;
  logic           accept, load;

  assign accept = start_i && !busy_q;
  assign load   = accept && !p_zero;

  div_prep #(.W(W)) u_prep (
    .mode_i     (mode_i),
    .sgn_i      (signed_i),
    .lo_i       (quo_val_i),
    .hi_i       (rem_val_i),
    .dvs_i      (divisor_i),
    .dvd_o      (p_dvd),
    .dvs_mag_o  (p_dvs),
    .steps_o    (p_steps),
    .dvd_neg_o  (p_dvd_neg),
    .dvs_neg_o  (p_dvs_neg),
    .dvs_zero_o (p_zero)
  );

  div_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .dvd_i   (p_dvd),
    .dvs_i   (p_dvs),
    .steps_i (p_steps),
    .busy_o  (c_busy),
    .fin_o   (c_fin),
    .quo_o   (c_quo),
    .rem_o   (c_rem)
  );

  div_post #(.W(W)) u_post (
    .mode_i (mode_q),
    .sgn_i  (sgn_q),
    .qneg_i (qneg_q),
    .rneg_i (rneg_q),
    .qmag_i (c_quo),
    .rmag_i (c_rem),
    .quot_o (r_quot),
    .rem_o  (r_rem),
    .ovf_o  (r_ovf),
    .neg_o  (r_neg),
    .zero_o (r_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      sgn_q   <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      qidx_q  <= '0;
      ridx_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      qwe_q   <= 1'b0;
      rwe_q   <= 1'b0;
      qaddr_q <= '0;
      raddr_q <= '0;
      qdata_q <= '0;
      rdata_q <= '0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
      v_q     <= 1'b0;
      c_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      qwe_q  <= 1'b0;
      rwe_q  <= 1'b0;
      if (accept) begin
        mode_q <= mode_i;
        sgn_q  <= signed_i;
        qneg_q <= p_dvd_neg ^ p_dvs_neg;
        rneg_q <= p_dvd_neg;
        qidx_q <= quo_idx_i;
        ridx_q <= rem_idx_i;
        if (p_zero) begin
          trap_q <= 1'b1;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end
      if (c_fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        c_q    <= 1'b0;
        if (r_ovf) begin
          v_q <= 1'b1;
          z_q <= 1'b0;
        end else begin
          v_q     <= 1'b0;
          n_q     <= r_neg;
          z_q     <= r_zero;
          qwe_q   <= 1'b1;
          qaddr_q <= qidx_q;
          qdata_q <= (mode_q == FORM_HALF) ? {r_rem[HW-1:0], r_quot[HW-1:0]} : r_quot;
          // equal indices: the quotient write wins
          rwe_q   <= (mode_q != FORM_HALF) && (ridx_q != qidx_q);
          raddr_q <= ridx_q;
          rdata_q <= r_rem;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign trap_o      = trap_q;
  assign quo_we_o    = qwe_q;
  assign quo_waddr_o = qaddr_q;
  assign quo_wdata_o = qdata_q;
  assign rem_we_o    = rwe_q;
  assign rem_waddr_o = raddr_q;
  assign rem_wdata_o = rdata_q;
  assign flag_n_o    = n_q;
  assign flag_z_o    = z_q;
  assign flag_v_o    = v_q;
  assign flag_c_o    = c_q;

  a_r3_trap_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !quo_we_o && !rem_we_o);
  a_r3_trap_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o}));
  a_r7_ovf_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trap_o && flag_v_o) |-> !quo_we_o && !rem_we_o && !flag_z_o);
  a_r7_ovf_n_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trap_o && flag_v_o) |-> $stable(flag_n_o));
  a_r9_quo_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_we_o |-> quo_we_o && (rem_waddr_o != quo_waddr_o));
  a_r5_half_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_we_o |-> (mode_q != FORM_HALF));
  a_r1_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !c_busy);
endmodule

// File: tb/div_unit_test.sv
`timescale 1ns/1ps
module div_unit_test;
  localparam int W  = 8;
  localparam int HW = W / 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic          sgn = 1'b0;
  logic [W-1:0]  qval = '0, rval = '0, dval = '0;
  logic [IW-1:0] qidx = '0, ridx = '0;
  logic          busy, done, trap, qwe, rwe, fn, fz, fv, fc;
  logic [IW-1:0] qaddr, raddr;
  logic [W-1:0]  qdata, rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic e_n = 1'b0, e_z = 1'b0, e_v = 1'b0, e_c = 1'b0;

  always #2.5 clk = ~clk;

  div_unit #(.W(W), .IW(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .signed_i(sgn),
    .quo_val_i(qval), .rem_val_i(rval), .divisor_i(dval),
    .quo_idx_i(qidx), .rem_idx_i(ridx),
    .busy_o(busy), .done_o(done), .trap_o(trap),
    .quo_we_o(qwe), .quo_waddr_o(qaddr), .quo_wdata_o(qdata),
    .rem_we_o(rwe), .rem_waddr_o(raddr), .rem_wdata_o(rdata),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint sx(longint v, int b);
    longint t;
    t = v << (64 - b);
    return t >>> (64 - b);
  endfunction

  function automatic longint zx(longint v, int b);
    return v & ((longint'(1) << b) - 1);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // form: 0 half, 1 single, 2 double; poke injects a start while busy (R2)
  task automatic do_op(int form, bit sg, int qv, int rv, int dv, int qi, int ri, bit poke);
    longint a, d, q, r, qd, rd;
    bit     trp, ovf, qen, ren, en_n, en_z;
    int     lat, n;
    string  mt, st;
    mt = (form == 0) ? "R5" : (form == 2) ? "R8" : "R10";
    st = sg ? "R11" : mt;
    if (form == 0) d = sg ? sx(zx(dv, HW), HW) : zx(dv, HW);
    else           d = sg ? sx(dv, W) : zx(dv, W);
    if (form == 2) a = sg ? sx((longint'(rv) << W) | qv, 2*W) : (longint'(rv) << W) | qv;
    else           a = sg ? sx(qv, W) : zx(qv, W);
    trp = (d == 0);
    q = 0; r = 0; ovf = 0;
    if (!trp) begin
      q = a / d;
      r = a % d;
      if (form == 0)
        ovf = sg ? (q < -(longint'(1) << (HW-1)) || q > (longint'(1) << (HW-1)) - 1)
                 : (q > (longint'(1) << HW) - 1);
      else if (form == 2)
        ovf = sg ? (q < -(longint'(1) << (W-1)) || q > (longint'(1) << (W-1)) - 1)
                 : (q > (longint'(1) << W) - 1);
    end
    qd  = (form == 0) ? ((zx(r, HW) << HW) | zx(q, HW)) : zx(q, W);
    rd  = zx(r, W);
    qen = !trp && !ovf;
    ren = qen && (form != 0) && (qi != ri);
    en_n = (form == 0) ? q[HW-1] : q[W-1];
    en_z = (form == 0) ? (zx(q, HW) == 0) : (zx(q, W) == 0);
    lat = trp ? 1 : ((form == 2) ? 2*W + 2 : W + 2);

    @(negedge clk);
    start = 1'b1; mode = 2'(form); sgn = sg;
    qval = W'(qv); rval = W'(rv); dval = W'(dv); qidx = IW'(qi); ridx = IW'(ri);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    n = 1;
    if (!trp) chk(busy === 1'b1, "R1", "busy after accept", busy, 1);
    while (!done && n < 300) begin
      if (poke && n == 3) begin
        start = 1'b1; dval = '0; mode = 2'd0;
      end else start = 1'b0;
      @(posedge clk); @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == lat, trp ? "R3" : "R1", "latency", n, lat);
    chk(busy === 1'b0, "R1", "busy at done", busy, 0);
    chk(trap === trp, trp ? "R3" : "R2", "trap", trap, trp);
    chk(qwe === qen, ovf ? "R7" : mt, "quo strobe", qwe, qen);
    chk(rwe === ren, (form == 0) ? "R5" : "R9", "rem strobe", rwe, ren);
    if (qen) begin
      chk(qaddr === IW'(qi), mt, "quo index", qaddr, qi);
      chk(longint'(qdata) == qd, st, "quo data", qdata, qd);
    end
    if (ren) begin
      chk(raddr === IW'(ri), "R9", "rem index", raddr, ri);
      chk(longint'(rdata) == rd, st, "rem data", rdata, rd);
    end
    if (!trp) begin
      e_c = 1'b0;
      if (ovf) begin e_v = 1'b1; e_z = 1'b0; end
      else begin e_v = 1'b0; e_n = en_n; e_z = en_z; end
    end
    chk(fv === e_v, (form == 0) ? "R6" : (form == 2) ? "R8" : "R10", "flag V", fv, e_v);
    chk(fn === e_n, ovf ? "R7" : mt, "flag N", fn, e_n);
    chk(fz === e_z, ovf ? "R7" : mt, "flag Z", fz, e_z);
    chk(fc === e_c, "R4", "flag C", fc, e_c);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R2", "no late op", {busy, done}, 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, trap, qwe, rwe} === 5'b0, "R1", "reset outputs", {busy, done, trap, qwe, rwe}, 0);
    chk({fn, fz, fv, fc} === 4'b0, "R1", "reset flags", {fn, fz, fv, fc}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed boundaries
    do_op(0, 0, 8'hF0, 0, 8'h0F, 1, 2, 0);   // R6 quotient 16 overflows
    do_op(0, 0, 8'hEF, 0, 8'h0F, 1, 2, 0);   // R6 quotient 15 fits
    do_op(1, 1, 8'h80, 0, 8'hFF, 3, 4, 0);   // R10 truncated, no overflow
    do_op(2, 1, 8'h00, 8'h80, 8'hFF, 5, 6, 0); // R8 signed overflow
    do_op(2, 0, 8'hFF, 8'hFF, 8'hFF, 5, 6, 0); // R8 unsigned overflow
    do_op(2, 0, 8'hFF, 8'hFE, 8'hFF, 5, 6, 0); // R8 quotient 255 fits
    do_op(1, 0, 8'd200, 0, 8'd7, 2, 2, 0);   // R9 equal indices
    do_op(2, 1, 8'h34, 8'hFF, 8'h00, 2, 3, 0); // R3 zero divisor
    do_op(0, 0, 8'h34, 0, 8'hF0, 2, 3, 0);   // R3 zero in half width
    do_op(1, 0, 8'd200, 0, 8'd7, 1, 2, 1);   // R2 start while busy

    // exhaustive half form
    for (int s = 0; s < 2; s++)
      for (int dv = 0; dv < 16; dv++)
        for (int qv = 0; qv < 256; qv++)
          do_op(0, s[0], qv, 0, dv | (int'($urandom_range(0, 15)) << HW),
                $urandom_range(0, 7), $urandom_range(0, 7), 0);

    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 500; k++) begin
        int qi = $urandom_range(0, 7);
        int ri = ($urandom_range(0, 3) == 0) ? qi : $urandom_range(0, 7);
        do_op(1, s[0], $urandom_range(0, 255), $urandom_range(0, 255),
              $urandom_range(0, 255), qi, ri, 0);
      end

    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 1000; k++) begin
        int qi = $urandom_range(0, 7);
        int ri = ($urandom_range(0, 3) == 0) ? qi : $urandom_range(0, 7);
        int rv = $urandom_range(0, 1) ? $urandom_range(0, 255) : $urandom_range(0, 7);
        if (s == 1 && $urandom_range(0, 1) == 1) rv = 255 - $urandom_range(0, 7);
        do_op(2, s[0], $urandom_range(0, 255), rv, $urandom_range(0, 255), qi, ri, 0);
      end

    finish_run();
  end
endmodule